// File: doc/BRIEF.md
# Embedded-Clock Two-Channel Serial Transmitter

This block carries two slow, unrelated logic levels across a single serial line, such as one optical fibre, with no separate clock. It runs on a local reference clock that is far faster than either input can toggle. Each input passes through a synchronizer and is captured once per frame. The capture becomes a 10-bit word that holds each input in true and inverted form, plus a fixed filler of three ones and three zeros. The word goes out one bit per clock, least significant bit first. A 1 is placed in front of it and a 0 after it, so every 12-bit frame holds a rising and a falling edge that a receiver can lock onto, and the frame carries equal numbers of ones and zeros.

A receiver that has lost lock can be served by raising the sync request. From the next frame boundary on, the line carries a fixed lock pattern: six ones followed by six zeros. The frame-start strobe marks the first bit of every frame, so neighbouring logic can align to the frame. The inputs are static levels, not a stream, so the edge of the block carries no valid/ready handshake and the serial output cannot be stalled: a new frame starts every 12 clocks without pause.

Top module: `emb_clk_serializer`

## Requirements
- R1: Frames follow each other with no gap, one bit per clock and 12 clocks per frame. `frame_start` is high for exactly one clock at the start of every frame and low at all other times.
- R2: Bit 0 of every frame on the line is a 1 (the start bit), and bit 11 is a 0 (the stop bit). `frame_start` is high in the same clock as the start bit.
- R3: In a data frame, line bits 1 to 10 carry payload bits 0 to 9 in order. Payload bit 0 is `din_a`, bit 1 is its inverse, bit 2 is `din_b`, bit 3 is its inverse, bits 4 to 6 are 1 and bits 7 to 9 are 0.
- R4: Every frame, whether data or sync, holds exactly six ones in its 12 line bits.
- R5: A frame that begins while `sync_req` is high is the lock pattern 111111000000 in line order, whatever the data inputs are.
- R6: `sync_req` is sampled only on the clock edge that starts a frame. A frame in flight is never cut short or changed, and a pulse on `sync_req` that rises and falls between two frame boundaries has no effect.
- R7: The inputs pass through a two-stage synchronizer and are captured once, at the frame boundary. A level held steady for the three edges up to and including the boundary edge appears in that frame. A pulse that starts and ends inside a frame, well before the boundary, does not reach the line.
- R8: While `rst_n` is low, `ser_out` and `frame_start` are low. The first rising edge after reset is released starts a fresh frame. The synchronizer is cleared by reset, so the first frame after reset carries both inputs as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock, also the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_a | input | 1 | First asynchronous logic-level input |
| din_b | input | 1 | Second asynchronous logic-level input |
| sync_req | input | 1 | Request to send lock-pattern frames |
| ser_out | output | 1 | Serial line output |
| frame_start | output | 1 | One-clock strobe on the start bit of each frame |

## Verification
The bench targets the latest input change that still reaches the next frame. A synchronizer or capture point that is off by one cycle would place the value a frame late, or would let it tear across frames. The bench raises and drops `sync_req` in the middle of a frame. A design that acted on the request at once would cut the current frame short or turn a glitch into a lock frame. The bench also resets the block mid-frame with both inputs high. A design that did not clear its synchronizer would send those ones in the first frame after reset, and one that kept its bit counter would start that frame at the wrong position. Mirrored or misordered payload bits are caught by comparing every line bit against its expected value, and a bad filler shows up in the count of ones per frame.

// File: rtl/eclk_pkg.sv
package eclk_pkg;
  localparam int NUM_IN    = 2;
  localparam int PAYLOAD_W = 10;
  localparam int FRAME_W   = PAYLOAD_W + 2;
  localparam int CNT_W     = $clog2(FRAME_W);
  localparam int MAP_W     = 2 * NUM_IN;
  localparam int FILL_ONES = (PAYLOAD_W - MAP_W) / 2;

  typedef logic [PAYLOAD_W-1:0] payload_t;

  // Lock pattern: the lower half of the payload set, so that with the start
  // and stop bits the line sees six ones then six zeros.
  localparam payload_t SYNC_WORD = payload_t'((1 << (PAYLOAD_W / 2)) - 1);
endpackage

// File: rtl/eclk_sync.sv
module eclk_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/eclk_payload_map.sv
module eclk_payload_map
  import eclk_pkg::*;
(
  input  logic [NUM_IN-1:0] lvl,
  output payload_t          word
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_pair
    assign word[2*i]   = lvl[i];
    assign word[2*i+1] = ~lvl[i];
  end

  for (genvar j = MAP_W; j < PAYLOAD_W; j++) begin : g_fill
    assign word[j] = (j < MAP_W + FILL_ONES) ? 1'b1 : 1'b0;
  end
endmodule

// File: rtl/eclk_framer.sv
module eclk_framer
  import eclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  payload_t data_word,
  input  logic     sync_req,
  output logic     ser_out,
  output logic     frame_start
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] cnt;
  payload_t         shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      shreg       <= '0;
      ser_out     <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= (cnt == '0);
      if (cnt == '0) begin
        shreg   <= sync_req ? SYNC_WORD : data_word;
        ser_out <= 1'b1;
        cnt     <= cnt + 1'b1;
      end else if (cnt == LAST) begin
        ser_out <= 1'b0;
        cnt     <= '0;
      end else begin
        ser_out <= shreg[0];
        shreg   <= shreg >> 1;
        cnt     <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer
  import eclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_a,
  input  logic din_b,
  input  logic sync_req,
  output logic ser_out,
  output logic frame_start
);
  logic [NUM_IN-1:0] lvl_sync;
  payload_t          data_word;

  eclk_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({din_b, din_a}),
    .d_sync  (lvl_sync)
  );

  eclk_payload_map u_map (
    .lvl  (lvl_sync),
    .word (data_word)
  );

  eclk_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_word   (data_word),
    .sync_req    (sync_req),
    .ser_out     (ser_out),
    .frame_start (frame_start)
  );
endmodule

// File: rtl/eclk_checker.sv
module eclk_checker
  import eclk_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic ser_out,
  input logic frame_start
);
  logic       seen;
  logic [4:0] pos;
  logic [4:0] ones;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      pos  <= '0;
      ones <= '0;
    end else if (frame_start) begin
      seen <= 1'b1;
      pos  <= 5'd1;
      ones <= {4'd0, ser_out};
    end else if (seen) begin
      pos  <= pos + 5'd1;
      ones <= ones + {4'd0, ser_out};
    end
  end

  assert_frame_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (frame_start == (pos == 5'(FRAME_W))));

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ser_out);

  assert_stop_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pos == 5'(FRAME_W - 1)) |-> !ser_out);

  assert_balance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pos == 5'(FRAME_W - 1)) |-> (ones == 5'(FRAME_W / 2)));
endmodule

bind emb_clk_serializer eclk_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ser_out     (ser_out),
  .frame_start (frame_start)
);

// File: tb/tb_emb_clk_serializer.sv
module tb_emb_clk_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din_a = 1'b0, din_b = 1'b0, sync_req = 1'b0;
  logic ser_out, frame_start;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  emb_clk_serializer dut (
    .clk(clk), .rst_n(rst_n), .din_a(din_a), .din_b(din_b),
    .sync_req(sync_req), .ser_out(ser_out), .frame_start(frame_start)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Line order: bit 0 is sent first.
  function automatic logic [11:0] exp_frame(input bit a, input bit b, input bit s);
    logic [9:0] p;
    p = s ? 10'b00000_11111 : {3'b000, 3'b111, ~b, b, ~a, a};
    return {1'b0, p, 1'b1};
  endfunction

  // Entered at the negedge of a frame's start bit. Captures that frame and
  // drives the stimulus for the following frame at index drive_at; with
  // glitch set, the opposite values are driven at index 1 first.
  task automatic collect(output logic [11:0] got, output bit strobe_ok,
                         input int drive_at, input bit na, input bit nb,
                         input bit ns, input bit glitch);
    strobe_ok = 1'b1;
    for (int idx = 0; idx < 12; idx++) begin
      got[idx] = ser_out;
      if (frame_start !== (idx == 0)) strobe_ok = 1'b0;
      if (glitch && idx == 1) begin
        din_a = ~na; din_b = ~nb; sync_req = ~ns;
      end
      if (idx == drive_at) begin
        din_a = na; din_b = nb; sync_req = ns;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input logic [11:0] got, input logic [11:0] exp,
                             input bit strobe_ok, input string req);
    check(strobe_ok, "R1", "frame_start pulse pattern", 0, 0);
    check(got[0] == 1'b1 && got[11] == 1'b0, "R2", "start/stop bits",
          int'(got), int'(exp));
    check($countones(got) == 6, "R4", "ones per frame", $countones(got), 6);
    check(got == exp, req, "frame bits", int'(got), int'(exp));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] got, cur;
    bit ok, a, b, s, g;
    int at;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    check(ser_out === 1'b0 && frame_start === 1'b0, "R8", "outputs in reset",
          {ser_out, frame_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_start === 1'b1, "R8", "first frame after release", frame_start, 1);
    cur = exp_frame(1'b0, 1'b0, 1'b0);

    for (int f = 0; f < 60; f++) begin
      g = 1'b0;
      case (f)
        0: begin a = 1; b = 1; s = 0; at = 0; end
        1: begin a = 1; b = 0; s = 0; at = 9; end   // R7 latest change
        2: begin a = 0; b = 1; s = 0; at = 5; end
        3: begin a = 1; b = 1; s = 1; at = 3; end   // R5
        4: begin a = 0; b = 0; s = 1; at = 9; end
        5: begin a = 1; b = 0; s = 0; at = 5; end   // R6 sync drops mid-frame
        6: begin a = 0; b = 0; s = 0; at = 4; g = 1; end  // R6 R7 glitch
        7: begin a = 1; b = 1; s = 0; at = 6; g = 1; end
        default: begin
          a = 1'($urandom); b = 1'($urandom);
          s = ($urandom % 4) == 0; at = $urandom % 10;
          g = ($urandom % 3) == 0;
          if (g && at < 3) at = 3;
        end
      endcase
      collect(got, ok, at, a, b, s, g);
      check_frame(got, cur, ok, cur == exp_frame(0, 0, 1) ? "R5 R6" : "R3 R7");
      cur = exp_frame(a, b, s);
    end

    // R8: reset in mid-frame with both inputs high
    for (int idx = 0; idx < 5; idx++) @(negedge clk);
    din_a = 1'b1; din_b = 1'b1; sync_req = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(ser_out === 1'b0 && frame_start === 1'b0, "R8", "mid-frame reset",
          {ser_out, frame_start}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_start === 1'b1, "R8", "fresh frame after reset", frame_start, 1);
    collect(got, ok, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    check_frame(got, exp_frame(0, 0, 0), ok, "R8");
    collect(got, ok, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    check_frame(got, exp_frame(1, 1, 0), ok, "R3 R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule